// File: doc/BRIEF.md
# Adaptive Cut-Through Transmit FIFO

This block buffers outgoing packets between a host-side writer that delivers words in bursts and a link-side transmitter that pulls one word per cycle at a fixed rate. It normally runs in cut-through fashion. A packet starts leaving as soon as the number of buffered words reaches a programmable start level, or as soon as the packet's final word has been stored, whichever happens first. This keeps latency low when the writer can keep up with the link.

If the buffer runs dry partway through a packet, the block ends that packet on the link with an error-marked terminating word. It pulses a retry request and discards the rest of the aborted packet as the writer delivers it. It then latches a store-and-forward fallback, so the writer's re-supplied packet, and every later one, is sent only once it is held complete. The fallback clears only on reset or on a clear strobe. Store-and-forward is also forced when the retry limit input is zero or when the start-level code selects it. In store-and-forward mode, a packet too large ever to be held complete is rejected and flushed.

Top module: `ct_txfifo`

## Requirements
- R1: The start-level code `cfg_thresh` selects a word count for a storage of DEPTH words. 2'b11 selects DEPTH/4, 2'b10 selects DEPTH/2, and 2'b01 selects floor(DEPTH*85/100). 2'b00 selects store-and-forward.
- R2: An idle packet starts when the buffered word count reaches the selected start level or when its end word has been stored, whichever comes first. The first word out carries `tx_sop`.
- R3: In store-and-forward mode, no word of a packet leaves until that packet's end word is stored.
- R4: An underrun occurs when `tx_ready` is high during a started packet and the buffer is empty. In that cycle the block outputs a word with `tx_valid`, `tx_eop` and `tx_err` all high and `tx_data` zero, and the packet ends.
- R5: `retry_req` pulses for exactly the underrun cycle. Every word of the aborted packet written from that cycle up to and including its end word is dropped.
- R6: After an underrun, `sf_mode` is 1 from the next cycle until reset or a `sf_clear` strobe. A clear restores threshold-based starting.
- R7: When `cfg_retry_limit` is zero, the block operates in store-and-forward mode whatever `cfg_thresh` holds.
- R8: In store-and-forward mode, a buffer that becomes full with no complete packet in it raises `oversize_err` for one cycle. The block then empties the buffer and drops the rest of that packet up to its end word.
- R9: `wr_ready` is low exactly when the buffer is full, except while a packet is being dropped. The stored word count never exceeds DEPTH.
- R10: After reset the buffer is empty, `wr_ready` is 1, `tx_valid` is 0 and the fallback latch is clear.
- R11: Words leave in write order. `tx_eop` marks each packet's final word and `tx_sop` marks its first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Writer presents a word |
| wr_ready | output | 1 | Block accepts the word this cycle |
| wr_data | input | DATA_W | Write word |
| wr_eop | input | 1 | Write word is the packet's last |
| tx_ready | input | 1 | Transmitter pulls a word this cycle |
| tx_valid | output | 1 | A word is delivered this cycle |
| tx_sop | output | 1 | Delivered word is a packet's first |
| tx_eop | output | 1 | Delivered word ends the packet |
| tx_err | output | 1 | Packet aborted by underrun |
| tx_data | output | DATA_W | Delivered word |
| cfg_thresh | input | 2 | Start-level code |
| cfg_retry_limit | input | RETRY_W | Retry limit, zero forces store-and-forward |
| sf_clear | input | 1 | Strobe clearing the fallback latch |
| sf_mode | output | 1 | Store-and-forward currently in force |
| retry_req | output | 1 | One-cycle retry request on underrun |
| oversize_err | output | 1 | One-cycle oversize rejection |

## Verification
The bound checker watches the invariants on every cycle. The fill count never passes DEPTH, and `wr_ready` tracks the full condition. An underrun always appears as an error-marked end word together with `retry_req`, and the fallback is set on the following cycle. No packet starts in store-and-forward mode without a complete packet stored, and an oversize rejection always leaves the buffer empty. Other behaviour depends on the order of events and only the bench scenarios show it. These scenarios cover the start cycle chosen by each start-level code, dropping the rest of an aborted packet, the re-supplied packet waiting for its end word, the clear strobe restoring cut-through, and flushing after an oversize rejection.

// File: rtl/ct_txfifo_pkg.sv
// Shared types for the cut-through transmit FIFO.
// Assumes: data width fixed at 32 bits by the word type below.
package ct_txfifo_pkg;
    localparam int WORD_W = 32;

    // One stored entry: payload word plus its end-of-packet flag.
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              eop;
    } entry_t;

    // Start-level codes.
    typedef enum logic [1:0] {
        TH_STORE = 2'b00,
        TH_HIGH  = 2'b01,
        TH_HALF  = 2'b10,
        TH_QTR   = 2'b11
    } thresh_code_e;
endpackage

// File: rtl/ct_txfifo_mem.sv
// Entry storage: synchronous write, combinational read of the head entry.
// Assumes: DEPTH is a power of two; the controller never writes when full.
module ct_txfifo_mem
    import ct_txfifo_pkg::*;
#(
    parameter int DEPTH = 512,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  entry_t           wr_entry,
    input  logic [PTR_W-1:0] rd_ptr,
    output entry_t           rd_entry
);
    entry_t store [DEPTH];

    // Write one entry at the tail.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr] <= wr_entry;
    end

    // Present the head entry.
    always_comb rd_entry = store[rd_ptr];
endmodule

// File: rtl/ct_txfifo_thresh.sv
// Decodes the start-level code into a word count and the forced store-and-forward flag.
// Assumes: configuration is static while a packet is in flight.
module ct_txfifo_thresh
    import ct_txfifo_pkg::*;
#(
    parameter int DEPTH   = 512,
    parameter int RETRY_W = 4,
    localparam int CNT_W  = $clog2(DEPTH) + 1,
    localparam int LVL_HI = (DEPTH * 85) / 100,
    localparam int LVL_HF = DEPTH / 2,
    localparam int LVL_QT = DEPTH / 4
) (
    input  logic [1:0]         code,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic [CNT_W-1:0]   start_words,
    output logic               force_sf
);
    // Map code to start level.
    always_comb begin
        unique case (thresh_code_e'(code))
            TH_HIGH: start_words = CNT_W'(LVL_HI);
            TH_HALF: start_words = CNT_W'(LVL_HF);
            TH_QTR:  start_words = CNT_W'(LVL_QT);
            default: start_words = CNT_W'(DEPTH);
        endcase
    end

    // Store-and-forward is forced by code 00 or a zero retry limit.
    always_comb force_sf = (thresh_code_e'(code) == TH_STORE) || (retry_limit == '0);
endmodule

// File: rtl/ct_txfifo_ctrl.sv
// Pointer, count and packet-state control for the cut-through transmit FIFO.
// Handles start decisions, underrun abort, drop of aborted/oversize packets,
// and the sticky store-and-forward fallback.
// Assumes: the transmitter pulls at most one word per cycle; DEPTH is a power of two.
module ct_txfifo_ctrl
    import ct_txfifo_pkg::*;
#(
    parameter int DEPTH   = 512,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic                wr_eop,
    output logic                wr_ready,
    output logic                wr_en,
    output logic [PTR_W-1:0]    wr_ptr,
    output logic [PTR_W-1:0]    rd_ptr,
    input  entry_t              head,
    input  logic                tx_ready,
    output logic                tx_valid,
    output logic                tx_sop,
    output logic                tx_eop,
    output logic                tx_err,
    output logic [WORD_W-1:0]   tx_data,
    input  logic [CNT_W-1:0]    start_words,
    input  logic                force_sf,
    input  logic                sf_clear,
    output logic                sf_mode,
    output logic                retry_req,
    output logic                oversize_err,
    output logic [CNT_W-1:0]    fill,
    output logic [CNT_W-1:0]    pkt_cnt
);
    logic in_tx, sf_latch, drop_q;
    logic full, empty, start_ok, pop, underrun, oversize, drop_now, wr_fire;

    // Derive per-cycle decisions from the registered state.
    always_comb begin
        full     = (fill == CNT_W'(DEPTH));
        empty    = (fill == '0);
        sf_mode  = force_sf || sf_latch;
        start_ok = !in_tx && !empty &&
                   ((pkt_cnt != '0) || (!sf_mode && (fill >= start_words)));
        pop      = tx_ready && !empty && (in_tx || start_ok);
        underrun = tx_ready && in_tx && empty;
        oversize = sf_mode && full && (pkt_cnt == '0) && !in_tx;
        drop_now = drop_q || underrun || oversize;
        wr_ready = !full || drop_q;
        wr_fire  = wr_valid && wr_ready;
        wr_en    = wr_fire && !drop_now;
    end

    // Drive the transmit side.
    always_comb begin
        tx_valid     = pop || underrun;
        tx_sop       = pop && !in_tx;
        tx_eop       = (pop && head.eop) || underrun;
        tx_err       = underrun;
        tx_data      = pop ? head.data : '0;
        retry_req    = underrun;
        oversize_err = oversize;
    end

    // Advance pointers, counts, packet state, drop state and fallback latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            fill     <= '0;
            pkt_cnt  <= '0;
            in_tx    <= 1'b0;
            drop_q   <= 1'b0;
            sf_latch <= 1'b0;
        end else begin
            drop_q <= drop_now && !(wr_fire && wr_eop);
            if (underrun)      sf_latch <= 1'b1;
            else if (sf_clear) sf_latch <= 1'b0;
            if (underrun)      in_tx <= 1'b0;
            else if (pop)      in_tx <= !head.eop;
            if (oversize) begin
                rd_ptr  <= wr_ptr;
                fill    <= '0;
                pkt_cnt <= '0;
            end else begin
                if (wr_en) wr_ptr <= wr_ptr + 1'b1;
                if (pop)   rd_ptr <= rd_ptr + 1'b1;
                fill    <= fill + CNT_W'(wr_en) - CNT_W'(pop);
                pkt_cnt <= pkt_cnt + CNT_W'(wr_en && wr_eop) - CNT_W'(pop && head.eop);
            end
        end
    end
endmodule

// File: rtl/ct_txfifo.sv
// Top of the adaptive cut-through transmit FIFO: storage, start-level decode and control.
// Assumes: DATA_W equals the package word width; DEPTH is a power of two.
module ct_txfifo
    import ct_txfifo_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 512,
    parameter int RETRY_W = 4,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    output logic               wr_ready,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_eop,
    input  logic               tx_ready,
    output logic               tx_valid,
    output logic               tx_sop,
    output logic               tx_eop,
    output logic               tx_err,
    output logic [DATA_W-1:0]  tx_data,
    input  logic [1:0]         cfg_thresh,
    input  logic [RETRY_W-1:0] cfg_retry_limit,
    input  logic               sf_clear,
    output logic               sf_mode,
    output logic               retry_req,
    output logic               oversize_err
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    entry_t           head, wr_entry;
    logic [CNT_W-1:0] start_words, fill, pkt_cnt;
    logic             force_sf;

    // Pack the incoming word with its end flag.
    always_comb wr_entry = '{data: WORD_W'(wr_data), eop: wr_eop};

    ct_txfifo_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_entry(wr_entry),
        .rd_ptr(rd_ptr), .rd_entry(head)
    );

    ct_txfifo_thresh #(.DEPTH(DEPTH), .RETRY_W(RETRY_W)) u_thr (
        .code(cfg_thresh), .retry_limit(cfg_retry_limit),
        .start_words(start_words), .force_sf(force_sf)
    );

    logic [WORD_W-1:0] tx_word;

    ct_txfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_eop(wr_eop), .wr_ready(wr_ready), .wr_en(wr_en),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .head(head),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_err(tx_err), .tx_data(tx_word),
        .start_words(start_words), .force_sf(force_sf), .sf_clear(sf_clear),
        .sf_mode(sf_mode), .retry_req(retry_req), .oversize_err(oversize_err),
        .fill(fill), .pkt_cnt(pkt_cnt)
    );

    // Resize the delivered word to the port width.
    always_comb tx_data = DATA_W'(tx_word);
endmodule

// File: rtl/ct_txfifo_chk.sv
// Assertion checker bound to ct_txfifo; observes ports and the fill/packet counters.
module ct_txfifo_chk #(
    parameter int DEPTH = 512,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ready,
    input logic             tx_valid,
    input logic             tx_sop,
    input logic             tx_eop,
    input logic             tx_err,
    input logic [31:0]      tx_data,
    input logic             sf_mode,
    input logic             retry_req,
    input logic             oversize_err,
    input logic [CNT_W-1:0] fill,
    input logic [CNT_W-1:0] pkt_cnt
);
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));

    // R9
    full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH)) |-> !wr_ready);

    // R4
    underrun_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_err |-> (tx_valid && tx_eop && tx_data == '0));

    // R5
    retry_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> tx_err);

    // R6
    fallback_after_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> sf_mode);

    // R3
    sf_start_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_mode && tx_sop) |-> (pkt_cnt != '0));

    // R8
    oversize_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oversize_err |=> (fill == '0));
endmodule

bind ct_txfifo ct_txfifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .tx_valid(tx_valid),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err), .tx_data(32'(tx_data)),
    .sf_mode(sf_mode), .retry_req(retry_req), .oversize_err(oversize_err),
    .fill(fill), .pkt_cnt(pkt_cnt)
);

// File: tb/ct_txfifo_bench.sv
// Self-checking bench: vector table of start-level cases, then directed
// reset, underrun/retry, fallback clear and oversize scenarios. DEPTH = 32.
module ct_txfifo_bench;
    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_eop = 1'b0, tx_ready = 1'b0, sf_clear = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  cfg_thresh = 2'b01;
    logic [3:0]  cfg_retry_limit = 4'd3;
    logic        wr_ready, tx_valid, tx_sop, tx_eop, tx_err, sf_mode, retry_req, oversize_err;
    logic [31:0] tx_data;

    int n_chk = 0, n_fail = 0;

    ct_txfifo #(.DATA_W(32), .DEPTH(DEPTH), .RETRY_W(4)) u_ct_txfifo (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_data(wr_data), .wr_eop(wr_eop), .tx_ready(tx_ready), .tx_valid(tx_valid),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err), .tx_data(tx_data),
        .cfg_thresh(cfg_thresh), .cfg_retry_limit(cfg_retry_limit), .sf_clear(sf_clear),
        .sf_mode(sf_mode), .retry_req(retry_req), .oversize_err(oversize_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Vector: code, retry limit, packet length, expected words written at start, kind.
    typedef struct packed {
        logic [1:0] code;
        logic [3:0] rl;
        logic [7:0] len;
        logic [7:0] exp_start;
        logic [3:0] kind;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'b01, 4'd3, 8'd30, 8'd27, 4'd1},
        '{2'b10, 4'd3, 8'd30, 8'd16, 4'd1},
        '{2'b11, 4'd3, 8'd20, 8'd8,  4'd1},
        '{2'b11, 4'd3, 8'd5,  8'd5,  4'd2},
        '{2'b10, 4'd3, 8'd12, 8'd12, 4'd2},
        '{2'b01, 4'd3, 8'd32, 8'd27, 4'd2},
        '{2'b00, 4'd3, 8'd20, 8'd20, 4'd3},
        '{2'b00, 4'd2, 8'd32, 8'd32, 4'd3},
        '{2'b11, 4'd0, 8'd20, 8'd20, 4'd7}
    };

    function automatic string kind_tag(input logic [3:0] k);
        case (k)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            default: return "R7";
        endcase
    endfunction

    // Send one packet with the transmitter always pulling; check start point and contents.
    task automatic run_packet(input logic [1:0] code, input logic [3:0] rl, input int len,
                              input int base, input int exp_start, input string req);
        int  written = 0, got = 0, start_at = -1;
        bit  bad = 0, done = 0, fire;
        cfg_thresh = code;
        cfg_retry_limit = rl;
        tx_ready = 1'b1;
        for (int cyc = 0; cyc < len + DEPTH + 10 && !done; cyc++) begin
            @(negedge clk);
            wr_valid = (written < len);
            wr_data  = 32'(base + written);
            wr_eop   = (written == len - 1);
            #1;
            fire = wr_valid && wr_ready;
            if (tx_valid) begin
                if (got == 0) start_at = written;
                if (tx_data != 32'(base + got) || tx_sop != (got == 0) ||
                    tx_eop != (got == len - 1) || tx_err) bad = 1;
                got++;
                if (tx_eop) done = 1;
            end
            @(posedge clk);
            if (fire) written++;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_eop = 1'b0;
        chk(start_at == exp_start, req, start_at, exp_start);
        // R11: order and packet markers
        chk(!bad && got == len, "R11", got, len);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int vcount;
        bit err_seen;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        chk(wr_ready == 1'b1, "R10", int'(wr_ready), 1);
        chk(tx_valid == 1'b0 && sf_mode == 1'b0, "R10", int'(tx_valid) + int'(sf_mode), 0);

        // Vector table walk.
        foreach (VECS[i])
            run_packet(VECS[i].code, VECS[i].rl, int'(VECS[i].len), 1000 * (i + 1),
                       int'(VECS[i].exp_start), kind_tag(VECS[i].kind));

        // R4/R5: underrun after 8 words with the writer stalled.
        cfg_thresh = 2'b11;
        cfg_retry_limit = 4'd3;
        tx_ready = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_data = 32'(k + 1); wr_eop = 1'b0;
        end
        @(negedge clk);
        wr_valid = 1'b0;
        vcount = 0;
        err_seen = 0;
        for (int c = 0; c < 20 && !err_seen; c++) begin
            #1;
            if (tx_valid) begin
                vcount++;
                if (tx_err) begin
                    err_seen = 1;
                    chk(tx_eop && tx_data == 32'd0, "R4", int'(tx_eop), 1);
                    chk(retry_req == 1'b1, "R5", int'(retry_req), 1);
                end
            end
            @(negedge clk);
        end
        chk(err_seen && vcount == 9, "R4", vcount, 9);
        #1;
        chk(retry_req == 1'b0, "R5", int'(retry_req), 0);
        chk(sf_mode == 1'b1, "R6", int'(sf_mode), 1);

        // R5: rest of the aborted packet is dropped.
        vcount = 0;
        for (int k = 8; k < 12; k++) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_data = 32'(k + 1); wr_eop = (k == 11);
            #1;
            if (tx_valid) vcount++;
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_eop = 1'b0;
        #1;
        if (tx_valid) vcount++;
        chk(vcount == 0, "R5", vcount, 0);

        // R6: re-supplied packet waits until complete despite a 8-word start level.
        run_packet(2'b11, 4'd3, 12, 1, 12, "R6");
        chk(sf_mode == 1'b1, "R6", int'(sf_mode), 1);

        // R6: clear strobe restores cut-through.
        @(negedge clk);
        sf_clear = 1'b1;
        @(negedge clk);
        sf_clear = 1'b0;
        #1;
        chk(sf_mode == 1'b0, "R6", int'(sf_mode), 0);
        run_packet(2'b11, 4'd3, 12, 200, 8, "R6");

        // R8/R9: oversize packet in store-and-forward mode (retry limit 0).
        cfg_thresh = 2'b01;
        cfg_retry_limit = 4'd0;
        vcount = 0;
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk);
            wr_valid = 1'b1; wr_data = 32'(k); wr_eop = 1'b0;
            #1;
            if (tx_valid) vcount++;
        end
        chk(vcount == 0, "R3", vcount, 0);
        @(negedge clk);
        #1;
        chk(wr_ready == 1'b0, "R9", int'(wr_ready), 0);
        chk(oversize_err == 1'b1, "R8", int'(oversize_err), 1);
        @(negedge clk);
        #1;
        chk(oversize_err == 1'b0 && wr_ready == 1'b1, "R8", int'(oversize_err), 0);
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            wr_valid = 1'b1; wr_data = 32'(900 + k); wr_eop = (k == 2);
        end
        @(negedge clk);
        wr_valid = 1'b0; wr_eop = 1'b0;
        run_packet(2'b01, 4'd0, 4, 500, 4, "R8");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule